// File: doc/BRIEF.md
# Block Register Transfer Address Sequencer

This block drives the address side of a multi-register memory transfer. Given a base address, a 16-bit register mask, a direction select, a before/after select and a writeback enable, it walks through the selected registers one per clock cycle. Each cycle it presents a word address and the index of the register that uses it. After the last one it pulses a completion flag, together with the updated base value and a flag that says whether the program counter was in the list.

Registers always leave in ascending index order, and the lowest-numbered register always gets the lowest address. The order in which the caller lists the registers therefore has no effect. In decrement modes the block first computes the bottom of the memory window and then still steps upward through it. With the two selects, the four modes cover full or empty stacks that grow upward or downward.

Top module: `lsm_addr_seq`

## Requirements
- R1: After reset, `busy`, `xfer_valid`, `done`, `base_we` and `flow_chg` are all low.
- R2: A start accepted with a non-empty mask produces exactly popcount(mask) consecutive cycles with `xfer_valid` high, beginning in the cycle after the start edge. Each cycle carries one set register index on `xfer_reg`, in strictly ascending order.
- R3: Addresses rise by 4 each transfer cycle. With n = popcount(mask), the first address is base when `upward`=1 and `pre_step`=0; base+4 when `upward`=1 and `pre_step`=1; base-4n+4 when `upward`=0 and `pre_step`=0; and base-4n when `upward`=0 and `pre_step`=1.
- R4: Bits [1:0] of every issued address are zero: the computed address has its two low bits cleared.
- R5: `done` is high for exactly one cycle, the cycle after the last transfer cycle, and `xfer_valid` is low in that cycle. In that cycle `new_base` equals base+4n when `upward`=1 and base-4n when `upward`=0.
- R6: In the `done` cycle, `base_we` equals the writeback enable captured at start. `base_we` is never high outside a `done` cycle.
- R7: An empty mask raises `done` in the cycle after the start edge with no transfer cycle, `base_we` low, and `new_base` equal to base.
- R8: `flow_chg` is high in the `done` cycle exactly when mask bit 15 (the program counter) was set, and is low in every other cycle.
- R9: `start` is ignored while `busy` is high: the ongoing sequence, its final base and its flags are unaffected by new inputs.
- R10: A full mask (all 16 bits set) produces 16 transfers covering indices 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer sequence (accepted when not busy) |
| base | input | AW | Base address |
| reg_mask | input | NREG | One bit per register to transfer |
| upward | input | 1 | 1 = increment, 0 = decrement |
| pre_step | input | 1 | 1 = step before access, 0 = after |
| wb_en | input | 1 | Request base writeback |
| busy | output | 1 | Sequence in progress |
| xfer_valid | output | 1 | Address and register index valid this cycle |
| xfer_addr | output | AW | Word-aligned memory address |
| xfer_reg | output | IW | Register index for this access |
| done | output | 1 | One-cycle completion pulse |
| new_base | output | AW | Updated base value, valid with done |
| base_we | output | 1 | Write new_base back to the base register |
| flow_chg | output | 1 | Program counter was transferred (with done) |

## Verification
Two things can fall in the same cycle: a new start, and an ongoing sequence, in either its transfer phase or its completion cycle. The bench raises `start` with a different base and a complemented mask in the middle of a sequence of three or more registers. It then checks that every remaining address, index, the written-back base and the program-counter flag still match the first request. Back-to-back runs also place a start directly after the `done` cycle. Empty-mask runs check that completion arrives in the very next cycle with no transfer cycle and no base change.

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base,
  input  logic [NREG-1:0] reg_mask,
  input  logic            upward,
  input  logic            pre_step,
  input  logic            wb_en,
  output logic            busy,
  output logic            xfer_valid,
  output logic [AW-1:0]   xfer_addr,
  output logic [IW-1:0]   xfer_reg,
  output logic            done,
  output logic [AW-1:0]   new_base,
  output logic            base_we,
  output logic            flow_chg
);
  localparam int CW = $clog2(NREG + 1);
  localparam logic [AW-1:0] WORD = AW'(4);

  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q, nb_q;
  logic            wb_q, pc_q, done_q, we_q, flow_q;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   span, first_addr, end_base;
  logic [IW-1:0]   low_idx;
  logic [NREG-1:0] rem_next;
  logic            accept;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CW'(reg_mask[i]);
  end

  always_comb begin
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem_q[i]) low_idx = IW'(i);
  end

  assign span       = AW'(cnt) << 2;
  assign first_addr = upward ? (pre_step ? base + WORD : base)
                             : (pre_step ? base - span : base - span + WORD);
  assign end_base   = upward ? base + span : base - span;
  assign rem_next   = rem_q & (rem_q - 1'b1);
  assign busy       = |rem_q;
  assign accept     = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
      nb_q   <= '0;
      wb_q   <= 1'b0;
      pc_q   <= 1'b0;
      done_q <= 1'b0;
      we_q   <= 1'b0;
      flow_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
      flow_q <= 1'b0;
      if (accept) begin
        rem_q  <= reg_mask;
        addr_q <= {first_addr[AW-1:2], 2'b00};
        wb_q   <= wb_en;
        pc_q   <= reg_mask[NREG-1];
        if (reg_mask == '0) begin
          nb_q   <= base;
          done_q <= 1'b1;
        end else begin
          nb_q <= end_base;
        end
      end else if (busy) begin
        rem_q  <= rem_next;
        addr_q <= addr_q + WORD;
        if (rem_next == '0) begin
          done_q <= 1'b1;
          we_q   <= wb_q;
          flow_q <= pc_q;
        end
      end
    end
  end

  assign xfer_valid = busy;
  assign xfer_addr  = addr_q;
  assign xfer_reg   = low_idx;
  assign done       = done_q;
  assign new_base   = nb_q;
  assign base_we    = we_q;
  assign flow_chg   = flow_q;
endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk #(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_valid,
  input logic [AW-1:0] xfer_addr,
  input logic [IW-1:0] xfer_reg,
  input logic          done,
  input logic          base_we,
  input logic          flow_chg
);
  // R4
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_addr[1:0] == 2'b00);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && $past(xfer_valid)) |-> xfer_addr == $past(xfer_addr) + AW'(4));
  // R2
  reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && $past(xfer_valid)) |-> xfer_reg > $past(xfer_reg));
  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_valid) |-> done);
  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_valid);
  // R6
  we_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> done);
  // R8
  flow_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_chg |-> done);
  // R7
  empty_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(xfer_valid)) |-> !base_we);
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
  .xfer_reg(xfer_reg), .done(done), .base_we(base_we), .flow_chg(flow_chg)
);

// File: tb/sim_lsm_addr_seq.sv
module sim_lsm_addr_seq;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] reg_mask = '0;
  logic        upward = 1'b0, pre_step = 1'b0, wb_en = 1'b0;
  logic        busy, xfer_valid, done, base_we, flow_chg;
  logic [31:0] xfer_addr, new_base;
  logic [3:0]  xfer_reg;
  int          vecs = 0, errs = 0;
  bit          finished = 0;

  lsm_addr_seq u0 (.*);

  always #10 clk = ~clk;

  function automatic int pop(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [31:0] exp_first(input logic [31:0] b, input int n,
                                            input logic up, input logic pre);
    logic [31:0] a;
    if (up) a = pre ? b + 32'd4 : b;
    else    a = pre ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] exp_wb(input logic [31:0] b, input int n, input logic up);
    return up ? b + 32'(4 * n) : b - 32'(4 * n);
  endfunction

  task automatic chk(input bit ok, input string req, input string msg);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic run(input logic [31:0] b, input logic [15:0] m, input logic up,
                     input logic pre, input logic wb, input bit poke);
    int n = pop(m);
    logic [31:0] a0 = exp_first(b, n, up, pre);
    int k = 0;
    base = b; reg_mask = m; upward = up; pre_step = pre; wb_en = wb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done && !xfer_valid && !base_we && new_base == b && !flow_chg, "R7",
          $sformatf("done=%0b valid=%0b we=%0b nb=%h flow=%0b exp done=1 valid=0 we=0 nb=%h flow=0",
                    done, xfer_valid, base_we, new_base, flow_chg, b));
    end else begin
      for (int i = 0; i < 16; i++) begin
        if (m[i]) begin
          if (k > 0) begin
            @(negedge clk);
            start = 1'b0;
          end
          chk(xfer_valid && !done && xfer_reg == 4'(i) && xfer_addr == a0 + 32'(4 * k),
              poke ? "R9" : (n == 16 ? "R10" : "R2/R3/R4"),
              $sformatf("valid=%0b reg=%0d addr=%h exp valid=1 reg=%0d addr=%h",
                        xfer_valid, xfer_reg, xfer_addr, i, a0 + 32'(4 * k)));
          if (poke && k == 1) begin
            start = 1'b1; base = ~b; reg_mask = ~m; upward = ~up; wb_en = ~wb;
          end
          k++;
        end
      end
      @(negedge clk);
      start = 1'b0;
      chk(done && !xfer_valid && new_base == exp_wb(b, n, up), "R5",
          $sformatf("done=%0b valid=%0b nb=%h exp done=1 valid=0 nb=%h",
                    done, xfer_valid, new_base, exp_wb(b, n, up)));
      chk(base_we == wb, "R6", $sformatf("we=%0b exp %0b", base_we, wb));
      chk(flow_chg == m[15], "R8", $sformatf("flow=%0b exp %0b", flow_chg, m[15]));
    end
    @(negedge clk);
    chk(!done && !base_we && !flow_chg && !busy, "R5",
        $sformatf("after done: done=%0b we=%0b flow=%0b busy=%0b exp all 0",
                  done, base_we, flow_chg, busy));
  endtask

  initial begin
    int waited = 0;
    while (!finished && waited < 100000) begin
      @(posedge clk);
      waited++;
    end
    if (!finished) begin
      errs++;
      vecs++;
      $display("FAIL watchdog: run did not end, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy && !xfer_valid && !done && !base_we && !flow_chg, "R1",
        $sformatf("busy=%0b valid=%0b done=%0b we=%0b flow=%0b exp all 0",
                  busy, xfer_valid, done, base_we, flow_chg));
    rst_n = 1'b1;
    @(negedge clk);
    run(32'h1000, 16'h0023, 1'b1, 1'b0, 1'b1, 0);
    run(32'h1000, 16'h0023, 1'b1, 1'b1, 1'b1, 0);
    run(32'h100C, 16'h0023, 1'b0, 1'b0, 1'b1, 0);
    run(32'h100C, 16'h0023, 1'b0, 1'b1, 1'b0, 0);
    run(32'h2000, 16'h0000, 1'b1, 1'b0, 1'b1, 0);
    run(32'h2000, 16'hFFFF, 1'b0, 1'b1, 1'b1, 0);
    run(32'h3000, 16'h8000, 1'b1, 1'b1, 1'b0, 0);
    run(32'h1003, 16'h0107, 1'b1, 1'b0, 1'b1, 0);
    run(32'h4000, 16'h80F1, 1'b0, 1'b0, 1'b1, 1);
    for (int t = 0; t < 300; t++) begin
      logic [15:0] m = 16'($urandom);
      logic [3:0]  sel = 4'($urandom);
      if (sel == 4'd0) m = '0;
      if (sel == 4'd1) m = '1;
      run($urandom, m, 1'($urandom), 1'($urandom), 1'($urandom), pop(m) >= 3 && sel[3]);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule